// File: doc/BRIEF.md
# Branch Condition Flag Unit

This block keeps two condition flags that the instruction decoder reads to choose between alternative subinstruction sequences. A sign flag records the sign of a value. A zero flag records whether a value was zero. The control pulse sequencer raises one or more test strobes during a subinstruction, together with a phase index. The block samples the write bus, the top bit of the adder output, or the memory buffer word in the phases the rules give, and updates the flags.

The zero flag has two tests that behave differently. The minus-zero test owns the flag: it clears the flag in its clear phase and may set it later. The plus-zero test can only set the flag. When the two tests run in the same subinstruction, the flag ends up as the OR of the two conditions. Words are 16-bit one's-complement, so minus zero is all ones and plus zero is all zeros.

Top module: `branch_cond_flags`

## Requirements
- R1: A synchronous active-high reset clears both flags, and the cleared values are visible in the cycle after reset.
- R2: In a cycle with no test strobe raised, both flags keep their values.
- R3: An adder-sign strobe in the set phase (phase index 4) loads the sign flag from the adder output's top bit and leaves the zero flag unchanged.
- R4: A bus-sign strobe in the set phase loads the sign flag from write-bus bit 15, the sign bit of the 16-bit word, and leaves the zero flag unchanged.
- R5: When the adder-sign and bus-sign strobes are raised together in the set phase, the adder bit wins.
- R6: A minus-zero strobe in the clear phase (phase index 3) clears the zero flag, whatever the bus holds.
- R7: A minus-zero strobe in the set phase sets the zero flag when the write bus is all ones (16'hFFFF). Otherwise the flag keeps its value.
- R8: A plus-zero strobe never clears the zero flag. In the set phase it sets the flag when the buffer word is all zeros (16'h0000), and in the clear phase it does nothing.
- R9: When minus-zero and plus-zero strobes are raised together, a clear phase followed by a set phase leaves the zero flag equal to the OR of the two zero conditions.
- R10: Strobes raised in any phase other than 3 or 4 leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tst_adder_sign_i | input | 1 | Test strobe: copy the adder top bit into the sign flag |
| tst_bus_sign_i | input | 1 | Test strobe: copy the write-bus sign bit into the sign flag |
| tst_minus_zero_i | input | 1 | Test strobe: clear the zero flag, then set it on a minus-zero bus |
| tst_plus_zero_i | input | 1 | Test strobe: set the zero flag on a plus-zero buffer word |
| phase_i | input | PHASE_W (4) | Phase index within the subinstruction |
| wbus_i | input | WORD_W (16) | Write bus word |
| adder_msb_i | input | 1 | Top bit of the adder output |
| buf_i | input | WORD_W (16) | Memory buffer word |
| sign_flag_o | output | 1 | Registered sign flag |
| zero_flag_o | output | 1 | Registered zero flag |

## Verification
Both flags are registers that drive the ports directly, so a wrong update shows at the outputs one clock after the phase that caused it, and it stays there until the next test strobe. The bench sweeps every strobe combination against every phase, both starting values of each flag, and bus, adder and buffer words on either side of the zero and sign conditions. Because the flags are preset just before each test, an illegal clear, a missing set or a wrong priority appears in the very next sample. A dedicated two-phase sequence checks the OR combination of the zero tests across the clear and set phases.

// File: rtl/bcf_pkg.sv
package bcf_pkg;
  localparam int DEF_WORD_W  = 16;
  localparam int DEF_PHASE_W = 4;

  typedef struct packed {
    logic adder_sign;
    logic bus_sign;
    logic minus_zero;
    logic plus_zero;
  } test_strobes_t;
endpackage

// File: rtl/bcf_word_match.sv
module bcf_word_match #(
  parameter int WORD_W     = 16,
  parameter bit MATCH_ONES = 1'b1
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              hit_o
);
  generate
    if (MATCH_ONES) begin : g_ones
      assign hit_o = &word_i;
    end else begin : g_zeros
      assign hit_o = ~|word_i;
    end
  endgenerate
endmodule

// File: rtl/bcf_sign_flag.sv
module bcf_sign_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_phase_i,
  input  logic tst_adder_i,
  input  logic tst_bus_i,
  input  logic adder_msb_i,
  input  logic bus_msb_i,
  output logic flag_o
);
  logic load;
  logic next_val;

  always_comb begin
    load     = set_phase_i && (tst_adder_i || tst_bus_i);
    next_val = tst_adder_i ? adder_msb_i : bus_msb_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       flag_o <= 1'b0;
    else if (load) flag_o <= next_val;
  end

  assert_sign_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(tst_adder_i || tst_bus_i) |=> $stable(flag_o));
  assert_adder_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (set_phase_i && tst_adder_i) |=> (flag_o == $past(adder_msb_i)));
  assert_bus_load_R4: assert property (@(posedge clk) disable iff (rst)
    (set_phase_i && tst_bus_i && !tst_adder_i) |=> (flag_o == $past(bus_msb_i)));
endmodule

// File: rtl/bcf_zero_flag.sv
module bcf_zero_flag (
  input  logic clk,
  input  logic rst,
  input  logic clr_phase_i,
  input  logic set_phase_i,
  input  logic tst_mz_i,
  input  logic tst_pz_i,
  input  logic mz_hit_i,
  input  logic pz_hit_i,
  output logic flag_o
);
  logic do_clear;
  logic do_set;

  always_comb begin
    do_clear = clr_phase_i && tst_mz_i;
    do_set   = set_phase_i && ((tst_mz_i && mz_hit_i) || (tst_pz_i && pz_hit_i));
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_o <= 1'b0;
    else if (do_clear) flag_o <= 1'b0;
    else if (do_set)   flag_o <= 1'b1;
  end

  assert_mz_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_phase_i && tst_mz_i) |=> !flag_o);
  assert_only_mz_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !(clr_phase_i && tst_mz_i)) |=> flag_o);
  assert_or_set_R9: assert property (@(posedge clk) disable iff (rst)
    (set_phase_i && ((tst_mz_i && mz_hit_i) || (tst_pz_i && pz_hit_i))) |=> flag_o);
  assert_zero_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(tst_mz_i || tst_pz_i) |=> $stable(flag_o));
endmodule

// File: rtl/branch_cond_flags.sv
module branch_cond_flags #(
  parameter int WORD_W    = bcf_pkg::DEF_WORD_W,
  parameter int PHASE_W   = bcf_pkg::DEF_PHASE_W,
  parameter int CLR_PHASE = 3,
  parameter int SET_PHASE = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tst_adder_sign_i,
  input  logic               tst_bus_sign_i,
  input  logic               tst_minus_zero_i,
  input  logic               tst_plus_zero_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [WORD_W-1:0]  wbus_i,
  input  logic               adder_msb_i,
  input  logic [WORD_W-1:0]  buf_i,
  output logic               sign_flag_o,
  output logic               zero_flag_o
);
  import bcf_pkg::*;

  localparam int SIGN_BIT = WORD_W - 1;
  localparam logic [PHASE_W-1:0] CLR_P = PHASE_W'(CLR_PHASE);
  localparam logic [PHASE_W-1:0] SET_P = PHASE_W'(SET_PHASE);

  test_strobes_t strb;
  logic clr_phase, set_phase;
  logic mz_hit, pz_hit;

  always_comb begin
    strb.adder_sign = tst_adder_sign_i;
    strb.bus_sign   = tst_bus_sign_i;
    strb.minus_zero = tst_minus_zero_i;
    strb.plus_zero  = tst_plus_zero_i;
    clr_phase       = (phase_i == CLR_P);
    set_phase       = (phase_i == SET_P);
  end

  bcf_word_match #(.WORD_W(WORD_W), .MATCH_ONES(1'b1)) u_mz (
    .word_i(wbus_i), .hit_o(mz_hit));
  bcf_word_match #(.WORD_W(WORD_W), .MATCH_ONES(1'b0)) u_pz (
    .word_i(buf_i), .hit_o(pz_hit));

  bcf_sign_flag u_sign (
    .clk(clk), .rst(rst), .set_phase_i(set_phase),
    .tst_adder_i(strb.adder_sign), .tst_bus_i(strb.bus_sign),
    .adder_msb_i(adder_msb_i), .bus_msb_i(wbus_i[SIGN_BIT]),
    .flag_o(sign_flag_o));

  bcf_zero_flag u_zero (
    .clk(clk), .rst(rst), .clr_phase_i(clr_phase), .set_phase_i(set_phase),
    .tst_mz_i(strb.minus_zero), .tst_pz_i(strb.plus_zero),
    .mz_hit_i(mz_hit), .pz_hit_i(pz_hit), .flag_o(zero_flag_o));

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!sign_flag_o && !zero_flag_o));
  assert_off_phase_R10: assert property (@(posedge clk) disable iff (rst)
    (phase_i != CLR_P && phase_i != SET_P) |=> ($stable(sign_flag_o) && $stable(zero_flag_o)));
  assert_sign_keeps_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (!tst_minus_zero_i && !tst_plus_zero_i) |=> $stable(zero_flag_o));
endmodule

// File: tb/branch_cond_flags_test.sv
module branch_cond_flags_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic t_as = 0, t_bs = 0, t_mz = 0, t_pz = 0;
  logic [3:0]  phase = '0;
  logic [15:0] wbus = '0;
  logic        amsb = 1'b0;
  logic [15:0] bufw = '0;
  logic sflag, zflag;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  branch_cond_flags uut (
    .clk(clk), .rst(rst),
    .tst_adder_sign_i(t_as), .tst_bus_sign_i(t_bs),
    .tst_minus_zero_i(t_mz), .tst_plus_zero_i(t_pz),
    .phase_i(phase), .wbus_i(wbus), .adder_msb_i(amsb), .buf_i(bufw),
    .sign_flag_o(sflag), .zero_flag_o(zflag));

  task automatic check(string req, logic es, logic ez);
    checks++;
    if (sflag !== es || zflag !== ez) begin
      failures++;
      $display("FAIL %s: sign=%b zero=%b expected sign=%b zero=%b", req, sflag, zflag, es, ez);
    end
  endtask

  task automatic idle();
    t_as = 0; t_bs = 0; t_mz = 0; t_pz = 0;
  endtask

  // bring both flags to (s,z) through the normal interface
  task automatic preset(logic s, logic z);
    @(negedge clk); rst = 1; idle();
    @(negedge clk); rst = 0;
    phase = 4'd4; t_as = 1; amsb = s; t_pz = 1; bufw = z ? 16'h0000 : 16'h0001;
  endtask

  function automatic string tag_of(int ph, logic as, logic bs, logic mz, logic pz);
    if (!(as || bs || mz || pz)) return "R2";
    if (ph != 3 && ph != 4) return "R10";
    if (ph == 3) return mz ? "R6" : "R8";
    if (as && bs) return "R5";
    if (mz && pz) return "R9";
    if (mz) return "R7";
    if (pz) return "R8";
    if (as) return "R3";
    return "R4";
  endfunction

  initial begin
    logic [15:0] bus_pat [4];
    logic [15:0] buf_pat [3];
    bus_pat[0] = 16'hFFFF; bus_pat[1] = 16'h0000; bus_pat[2] = 16'h8000; bus_pat[3] = 16'h7FFF;
    buf_pat[0] = 16'h0000; buf_pat[1] = 16'h0001; buf_pat[2] = 16'h8000;

    repeat (2) @(negedge clk);
    rst = 0; idle();
    @(negedge clk);
    check("R1", 1'b0, 1'b0);

    for (int st = 0; st < 16; st++)
      for (int ph = 0; ph < 8; ph++)
        for (int init = 0; init < 4; init++)
          for (int bi = 0; bi < 4; bi++)
            for (int fi = 0; fi < 3; fi++)
              for (int a = 0; a < 2; a++) begin
                logic as, bs, mz, pz, s0, z0, es, ez;
                as = st[0]; bs = st[1]; mz = st[2]; pz = st[3];
                s0 = init[0]; z0 = init[1];
                preset(s0, z0);
                @(negedge clk);
                idle();
                t_as = as; t_bs = bs; t_mz = mz; t_pz = pz;
                phase = 4'(ph); wbus = bus_pat[bi]; bufw = buf_pat[fi]; amsb = a[0];
                @(negedge clk);
                idle();
                es = s0; ez = z0;
                if (ph == 4) begin
                  if (as) es = a[0];
                  else if (bs) es = bus_pat[bi][15];
                  ez = z0 | (mz & (bus_pat[bi] == 16'hFFFF)) | (pz & (buf_pat[fi] == 16'h0000));
                end else if (ph == 3 && mz) begin
                  ez = 1'b0;
                end
                check(tag_of(ph, as, bs, mz, pz), es, ez);
              end

    // R9 sequence: zero flag set, then clear phase and set phase with both zero tests
    for (int c = 0; c < 4; c++) begin
      logic ez;
      preset(1'b0, 1'b1);
      @(negedge clk);
      idle(); t_mz = 1; t_pz = 1; phase = 4'd3; wbus = 16'h0000; bufw = 16'h0000;
      @(negedge clk);
      check("R6", 1'b0, 1'b0);
      phase = 4'd4;
      wbus = c[0] ? 16'hFFFF : 16'hFFFE;
      bufw = c[1] ? 16'h0000 : 16'h0400;
      ez = c[0] | c[1];
      @(negedge clk);
      idle();
      check("R9", 1'b0, ez);
    end

    // R1: reset from both flags set
    preset(1'b1, 1'b1);
    @(negedge clk);
    idle(); rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1", 1'b0, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule